// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs one complete management transaction on the two-wire serial bus that connects an Ethernet MAC to an external PHY. A host pulses a start input together with an operation select (read or write), a 5-bit PHY address, a 5-bit register number and 16 bits of write data. The block then clocks a full frame onto the management clock, data output and data output-enable pins. During the input phase of a read, it samples the data input pin.

Each frame opens with a 32-bit all-ones preamble. A start code, an opcode and the two address fields follow. Next come a released turnaround and the 16-bit data phase. A single released trailing clock closes the frame. The two operations differ in length:

- A read releases the line for one turnaround bit, samples 16 bits, and then gives one released clock. It is 64 bit times in total.
- A write releases the line for two turnaround bits, drives 16 bits, and then gives one released clock. It is 65 bit times in total.

The length of each clock phase is set in system clocks by an input that is latched at start. When the frame ends, the block raises a one-cycle done pulse and presents the read data. The read data stays unchanged until the next accepted start.

Top module: `mdio_frame_master`

## Requirements
- R1: While no frame is in progress, including straight after reset, mgmt_clk_o, mgmt_oe_o and mgmt_do_o are all 0, and rd_data_o is 0 after reset.
- R2: Bit times 0 to 31 of every frame drive the line high with the output-enable asserted.
- R3: Bit times 32 and 33 drive 0 then 1. Bit times 34 and 35 drive 1 then 0 for a read (is_write_i = 0), and 0 then 1 for a write (is_write_i = 1).
- R4: Bit times 36 to 40 drive phy_addr_i[4] down to phy_addr_i[0]. Bit times 41 to 45 drive reg_addr_i[4] down to reg_addr_i[0]. All ten bits are driven with the output-enable asserted.
- R5: A read frame is 64 bit times long. Bit 46 is released. Bits 47 to 62 are released, and each is sampled into rd_data_o from bit 15 down to bit 0. Bit 63 is released. Each input bit is taken from mgmt_di_i at the system clock edge that ends the high phase of that bit time.
- R6: A write frame is 65 bit times long. Bits 46 and 47 are released. Bits 48 to 63 drive wr_data_i[15] down to wr_data_i[0] with the output-enable asserted. Bit 64 is released. "Released" means that the output-enable and the data output are both 0.
- R7: Every bit time is half_cycles_i system clocks with mgmt_clk_o low, followed by the same number of clocks with it high. A value of 0 acts as 1. The output-enable and data output do not change within a bit time.
- R8: busy_o goes high in the cycle after an accepted start and stays high until the frame ends. A start that arrives while busy_o is high is ignored, and so are the fields presented with it.
- R9: done_o is a one-cycle pulse in the first cycle after the last bit time, with busy_o low. rd_data_o then holds its value until the next accepted start. A write frame returns 0 on rd_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, accepted when not busy |
| is_write_i | input | 1 | 1 selects a write frame, 0 a read frame |
| phy_addr_i | input | 5 | PHY address of the transaction |
| reg_addr_i | input | 5 | Register number of the transaction |
| wr_data_i | input | 16 | Data for a write frame |
| half_cycles_i | input | DIV_W | System clocks per clock phase (0 acts as 1) |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| rd_data_o | output | 16 | Data captured by the last read, 0 after a write |
| mgmt_clk_o | output | 1 | Management clock |
| mgmt_do_o | output | 1 | Management data output |
| mgmt_oe_o | output | 1 | Management data output-enable |
| mgmt_di_i | input | 1 | Management data input |

## Verification
The assertions assume two things about the inputs. First, the request fields and half_cycles_i are only meaningful in the cycle a start is accepted. Second, mgmt_di_i is settled by the clock edge that closes each high phase.

The stimulus changes its inputs only at falling system clock edges. It presents mgmt_di_i as the inverse of the intended bit during the low phase and as the true bit during the high phase, so a sample taken in the wrong phase shows up as wrong read data. It also raises start with conflicting fields in the middle of a frame to exercise the ignore rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BIT_W = 7;
  localparam logic [BIT_W-1:0] PRE_LAST  = 7'd31;
  localparam logic [BIT_W-1:0] ST_LO     = 7'd32;
  localparam logic [BIT_W-1:0] ST_HI     = 7'd33;
  localparam logic [BIT_W-1:0] OP_A      = 7'd34;
  localparam logic [BIT_W-1:0] OP_B      = 7'd35;
  localparam logic [BIT_W-1:0] PA_LAST   = 7'd40;
  localparam logic [BIT_W-1:0] RA_LAST   = 7'd45;
  localparam logic [BIT_W-1:0] RD_IN_LO  = 7'd47;
  localparam logic [BIT_W-1:0] RD_IN_HI  = 7'd62;
  localparam logic [BIT_W-1:0] RD_FINAL  = 7'd63;
  localparam logic [BIT_W-1:0] WR_OUT_LO = 7'd48;
  localparam logic [BIT_W-1:0] WR_OUT_HI = 7'd63;
  localparam logic [BIT_W-1:0] WR_FINAL  = 7'd64;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
endpackage

// File: rtl/mdio_timebase.sv
module mdio_timebase #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             phase_o,
  output logic             bit_end_o
);
  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             phase_q, phase_d;
  logic             half_end;

  assign half_end  = run_i && (div_q == half_q - DIV_W'(1));
  assign bit_end_o = half_end && phase_q;
  assign phase_o   = phase_q;

  always_comb begin
    half_d  = half_q;
    div_d   = div_q;
    phase_d = phase_q;
    if (load_i) begin
      half_d  = (half_i == '0) ? DIV_W'(1) : half_i;
      div_d   = '0;
      phase_d = 1'b0;
    end else if (run_i) begin
      if (half_end) begin
        div_d   = '0;
        phase_d = ~phase_q;
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= DIV_W'(1);
      div_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      half_q  <= half_d;
      div_q   <= div_d;
      phase_q <= phase_d;
    end
  end

  // R7: divider never leaves its window and the phase length is never zero
  p_div_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (half_q != '0) && (div_q < half_q));
  // R7: the phase flips only at the end of a phase
  p_phase_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && !half_end) |=> $stable(phase_q));
endmodule

// File: rtl/mdio_field_mux.sv
module mdio_field_mux
  import mdio_pkg::*;
(
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              oe_o,
  output logic              val_o,
  output logic              sample_o,
  output logic              last_o
);
  logic [BIT_W-1:0] off_phy, off_reg, off_dat;

  assign off_phy = PA_LAST - bit_i;
  assign off_reg = RA_LAST - bit_i;
  assign off_dat = WR_OUT_HI - bit_i;
  assign last_o  = wr_i ? (bit_i == WR_FINAL) : (bit_i == RD_FINAL);

  always_comb begin
    oe_o     = 1'b0;
    val_o    = 1'b0;
    sample_o = 1'b0;
    if (bit_i <= PRE_LAST) begin
      oe_o  = 1'b1;
      val_o = 1'b1;
    end else if (bit_i == ST_LO) begin
      oe_o = 1'b1;
    end else if (bit_i == ST_HI) begin
      oe_o  = 1'b1;
      val_o = 1'b1;
    end else if (bit_i == OP_A) begin
      oe_o  = 1'b1;
      val_o = ~wr_i;
    end else if (bit_i == OP_B) begin
      oe_o  = 1'b1;
      val_o = wr_i;
    end else if (bit_i <= PA_LAST) begin
      oe_o  = 1'b1;
      val_o = phy_i[off_phy[2:0]];
    end else if (bit_i <= RA_LAST) begin
      oe_o  = 1'b1;
      val_o = reg_i[off_reg[2:0]];
    end else if (wr_i) begin
      if (bit_i >= WR_OUT_LO && bit_i <= WR_OUT_HI) begin
        oe_o  = 1'b1;
        val_o = wdata_i[off_dat[3:0]];
      end
    end else begin
      sample_o = (bit_i >= RD_IN_LO) && (bit_i <= RD_IN_HI);
    end
  end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic [4:0]        phy_addr_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic [DIV_W-1:0]  half_cycles_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       rd_data_o,
  output logic              mgmt_clk_o,
  output logic              mgmt_do_o,
  output logic              mgmt_oe_o,
  input  logic              mgmt_di_i
);
  logic rst_s1, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_s <= rst_s1;
    end
  end

  logic              busy_q, busy_d, done_q, done_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              wr_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic              accept, phase, bit_end;
  logic              f_oe, f_val, f_smp, f_last;

  assign accept = start_i && !busy_q;

  mdio_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (accept),
    .run_i     (busy_q),
    .half_i    (half_cycles_i),
    .phase_o   (phase),
    .bit_end_o (bit_end)
  );

  mdio_field_mux u_mux (
    .bit_i    (bit_q),
    .wr_i     (wr_q),
    .phy_i    (phy_q),
    .reg_i    (reg_q),
    .wdata_i  (wdata_q),
    .oe_o     (f_oe),
    .val_o    (f_val),
    .sample_o (f_smp),
    .last_o   (f_last)
  );

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    bit_d   = bit_q;
    rdata_d = rdata_q;
    if (accept) begin
      busy_d  = 1'b1;
      bit_d   = '0;
      rdata_d = '0;
    end else if (busy_q && bit_end) begin
      if (f_smp) rdata_d = {rdata_q[DATA_W-2:0], mgmt_di_i};
      if (f_last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= is_write_i;
      phy_q   <= phy_addr_i;
      reg_q   <= reg_addr_i;
      wdata_q <= wr_data_i;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rd_data_o  = rdata_q;
  assign mgmt_clk_o = busy_q && phase;
  assign mgmt_oe_o  = busy_q && f_oe;
  assign mgmt_do_o  = busy_q && f_oe && f_val;

  // R1: pins quiet outside a frame
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_o |-> (!mgmt_clk_o && !mgmt_oe_o && !mgmt_do_o));
  // R5: input bits are taken with the line released and the clock high
  p_sample_released_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_q && bit_end && f_smp) |-> (!mgmt_oe_o && mgmt_clk_o));
  // R7: drive pins constant inside a bit time
  p_bit_stable_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_q && !bit_end) |=> ($stable(mgmt_oe_o) && $stable(mgmt_do_o)));
  // R8: a start while busy leaves the latched request untouched
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && start_i) |=> ($stable(wr_q) && $stable(phy_q) && $stable(reg_q) && $stable(wdata_q)));
  // R8: busy only ends with done
  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(busy_o) |-> done_o);
  // R9: done is a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);
  // R9: read data held while idle and no start
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy_o && !start_i) |=> $stable(rd_data_o));
  // R9: a write returns zero
  p_write_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && wr_q) |-> (rd_data_o == '0));
endmodule

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
  localparam int DW = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, is_write_i = 1'b0, mgmt_di_i = 1'b1;
  logic [4:0]    phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0]   wr_data_i = '0;
  logic [DW-1:0] half_cycles_i = '0;
  logic          busy_o, done_o, mgmt_clk_o, mgmt_do_o, mgmt_oe_o;
  logic [15:0]   rd_data_o;

  mdio_frame_master #(.DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
    .half_cycles_i(half_cycles_i), .busy_o(busy_o), .done_o(done_o),
    .rd_data_o(rd_data_o), .mgmt_clk_o(mgmt_clk_o), .mgmt_do_o(mgmt_do_o),
    .mgmt_oe_o(mgmt_oe_o), .mgmt_di_i(mgmt_di_i)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_on = 0, m_go = 0, m_active = 0, m_wr = 0;
  int m_c = 0, m_h = 1, m_len = 64;
  logic [15:0] m_rval = '0, m_rexp = '0, m_hold = '0;
  logic [1:0]  frame_q[$];

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at model cycle %0d: actual %h expected %h", tag, what, m_c, act, exp);
    end
  endtask

  function automatic string tag_of(int b, bit wr);
    if (b < 32) return "R2";
    if (b < 36) return "R3";
    if (b < 46) return "R4";
    return wr ? "R6" : "R5";
  endfunction

  task automatic build(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    frame_q.delete();
    for (int i = 0; i < 32; i++) frame_q.push_back(2'b11);
    frame_q.push_back(2'b10);
    frame_q.push_back(2'b11);
    frame_q.push_back(wr ? 2'b10 : 2'b11);
    frame_q.push_back(wr ? 2'b11 : 2'b10);
    for (int i = 4; i >= 0; i--) frame_q.push_back({1'b1, pa[i]});
    for (int i = 4; i >= 0; i--) frame_q.push_back({1'b1, ra[i]});
    frame_q.push_back(2'b00);
    if (wr) begin
      frame_q.push_back(2'b00);
      for (int i = 15; i >= 0; i--) frame_q.push_back({1'b1, wd[i]});
    end else begin
      for (int i = 0; i < 16; i++) frame_q.push_back(2'b00);
    end
    frame_q.push_back(2'b00);
  endtask

  task automatic launch(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd,
                        int h, logic [15:0] rv);
    @(negedge clk);
    start_i = 1'b1; is_write_i = wr; phy_addr_i = pa; reg_addr_i = ra;
    wr_data_i = wd; half_cycles_i = DW'(h);
    if (!m_active) begin
      build(wr, pa, ra, wd);
      m_wr = wr; m_h = (h == 0) ? 1 : h; m_len = wr ? 65 : 64;
      m_rval = rv; m_rexp = wr ? 16'h0000 : rv; m_go = 1;
    end
    @(negedge clk);
    start_i = 1'b0;
    is_write_i = ~wr; phy_addr_i = ~pa; reg_addr_i = ~ra; wr_data_i = ~wd;
    half_cycles_i = DW'(7);
  endtask

  task automatic wait_idle(int extra);
    while (m_active || m_go) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  // PHY model: inverse bit in low phase, true bit in high phase
  always @(negedge clk) begin
    if (m_active && !m_wr) begin
      int b; bit hi;
      b  = m_c / (2 * m_h);
      hi = (m_c % (2 * m_h)) >= m_h;
      if (b >= 47 && b <= 62) mgmt_di_i = hi ? m_rval[62-b] : ~m_rval[62-b];
      else mgmt_di_i = 1'b1;
    end else begin
      mgmt_di_i = 1'b1;
    end
  end

  // Reference model compared every clock
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
      if (m_go) begin m_go = 0; m_active = 1; m_c = 0; end
      else if (m_active) m_c++;
      if (m_active) begin
        int t; int b; bit hi; string tg;
        t = m_len * 2 * m_h;
        if (m_c < t) begin
          b  = m_c / (2 * m_h);
          hi = (m_c % (2 * m_h)) >= m_h;
          tg = tag_of(b, m_wr);
          chk("R7", "clock phase", 16'(mgmt_clk_o), 16'(hi));
          chk(tg, "output-enable", 16'(mgmt_oe_o), 16'(frame_q[b][1]));
          chk(tg, "data out", 16'(mgmt_do_o), 16'(frame_q[b][0]));
          chk("R8", "busy in frame", 16'(busy_o), 16'd1);
          chk("R9", "done in frame", 16'(done_o), 16'd0);
        end else begin
          chk("R8", "busy at end", 16'(busy_o), 16'd0);
          chk("R9", "done at end", 16'(done_o), 16'd1);
          chk("R1", "pins at end", {13'd0, mgmt_clk_o, mgmt_oe_o, mgmt_do_o}, 16'd0);
          chk(m_wr ? "R9" : "R5", "read data", rd_data_o, m_rexp);
          m_hold = m_rexp;
          m_active = 0;
        end
      end else begin
        chk("R1", "idle pins", {13'd0, mgmt_clk_o, mgmt_oe_o, mgmt_do_o}, 16'd0);
        chk("R8", "idle busy", 16'(busy_o), 16'd0);
        chk("R9", "idle done", 16'(done_o), 16'd0);
        chk("R9", "held data", rd_data_o, m_hold);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1;
    repeat (4) @(negedge clk);
    // R5 read, fastest clock
    launch(1'b0, 5'h11, 5'h02, 16'h0000, 1, 16'hA5C3);
    wait_idle(3);
    // R6 write, slow clock
    launch(1'b1, 5'h00, 5'h00, 16'h8421, 3, 16'h0000);
    wait_idle(3);
    // R7 zero acts as one; R4 all-ones addresses
    launch(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 0, 16'h8001);
    wait_idle(2);
    // R8 start while busy is ignored
    fork
      launch(1'b1, 5'h0A, 5'h15, 16'h5AF0, 2, 16'h0000);
      begin
        repeat (40) @(negedge clk);
        launch(1'b0, 5'h1B, 5'h04, 16'h1234, 1, 16'hFFFF);
      end
    join
    wait_idle(3);
    // R9 read data held across idle time
    launch(1'b0, 5'h05, 5'h12, 16'h0000, 2, 16'h7E18);
    wait_idle(20);
    // back-to-back start right after done
    launch(1'b0, 5'h01, 5'h01, 16'h0000, 1, 16'h0F0F);
    wait_idle(0);
    launch(1'b1, 5'h1E, 5'h0F, 16'hC003, 1, 16'h0000);
    wait_idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule